// File: doc/BRIEF.md
# Secure-Aware Priority Mask Register

This unit sits in the CPU interface of an interrupt controller. It keeps an 8-bit priority mask and lets software read the running priority of the interface, which is supplied from outside. Both are reached through a plain register port with single-cycle write and read strobes. Each access carries a flag that marks it as secure or non-secure.

When the security extension is present and group-0 interrupts are routed away from the non-secure world, non-secure software gets a compressed view of priorities. Real values with the top bit clear belong to the secure half and are hidden. The upper half is stretched over the whole non-secure range. The unit converts non-secure reads and writes into this view. A non-secure write cannot change a mask that currently holds a secure-half value.

A combinational mask-pass output compares a candidate interrupt priority against the stored mask. A one-cycle pulse marks each write that changes the mask, so that pending-interrupt signalling can be evaluated again.

Top module: `prio_mask_unit`

## Requirements
- R1: After synchronous reset the stored mask is 0x00, `rdata` is 0x00, `reeval` is 0, and `mask_pass` is 0 for every candidate.
- R2: An untranslated write with `reg_sel`=0 stores `wdata` unchanged. A read with `rd_en` loads `rdata` on the next clock edge, and `rdata` holds its value while there is no read. `reg_sel`=0 selects the mask and `reg_sel`=1 selects the running priority.
- R3: Translation applies only when `sec_ext_en`, `grp0_route` and `acc_ns` are all 1. If any of them is 0, reads and writes use raw values.
- R4: A translated read of a value whose bit 7 is 0 returns 0x00.
- R5: A translated read of a value whose bit 7 is 1 returns the value shifted left by one and truncated to 8 bits. The value 0xFF is the exception and reads as 0xFF. For example, 0xC0 reads as 0x80.
- R6: A translated write while the stored mask has bit 7 = 0 is ignored. The mask keeps its value and no `reeval` pulse follows.
- R7: Any other translated write stores `{1'b1, wdata[7:1]}`, so 0xFE and 0xFF both store 0xFF.
- R8: A read with `reg_sel`=1 returns `run_prio`, translated under the same rule as the mask. A write with `reg_sel`=1 has no effect.
- R9: `mask_pass` is 1 exactly when `cand_prio` is numerically below the stored mask. It follows a new mask in the cycle after the write.
- R10: `reeval` is high for one cycle after each clock edge that accepts a mask write, and low otherwise.
- R11: A read and a write of the mask in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_ext_en | input | 1 | Security extension present |
| grp0_route | input | 1 | Group-0 routed away from non-secure world |
| acc_ns | input | 1 | Access is non-secure |
| reg_sel | input | 1 | 0 = mask, 1 = running priority |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| run_prio | input | 8 | Current running priority (0xFF when idle) |
| cand_prio | input | 8 | Candidate interrupt priority |
| mask_pass | output | 1 | Candidate priority is below the mask |
| reeval | output | 1 | Pulse after an accepted mask write |

## Verification
The two functions that can fall in the same cycle are a mask read and a mask write. Either can be translated or raw, and a translated write may be blocked. The bench issues them together: once in a directed case, and many times in the random phase, where the strobes, the security flags and the select are drawn independently. The reference model computes the expected read data from the mask as it was before the write, then applies the write. Each cycle it judges `rdata`, `reeval` and `mask_pass` against the model.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_RUN  = 1'b1
  } pmr_sel_e;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/pmr_view_xlate.sv
// Converts a real priority into the non-secure view when enabled.
module pmr_view_xlate #(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  logic [W-1:0] raw,
  output logic [W-1:0] view
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_comb begin
    if (!en) begin
      view = raw;
    end else if (!raw[W-1]) begin
      view = '0;                       // secure half hidden
    end else if (raw == ALL_ONES) begin
      view = raw;                      // top value kept as is
    end else begin
      view = {raw[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/pmr_mask_reg.sv
// Mask storage with the non-secure write rule and update pulse.
module pmr_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         xlate,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic         upd_q
);
  logic         blocked;
  logic         accept;
  logic [W-1:0] next_val;

  always_comb begin
    blocked  = xlate && !mask_q[W-1];
    accept   = wr_en && !blocked;
    next_val = xlate ? {1'b1, wdata[W-1:1]} : wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= accept;
      if (accept) begin
        mask_q <= next_val;
      end
    end
  end

  AST_NS_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && xlate && !mask_q[W-1]) |=> $stable(mask_q)); // R6
  AST_NS_WR_TOPBIT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && xlate && mask_q[W-1]) |=> mask_q[W-1]); // R7
  AST_NO_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_q)); // R2
  AST_PULSE_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> $past(wr_en)); // R10
endmodule

// File: rtl/pmr_read_port.sv
// Translates both readable sources and registers the selected one.
module pmr_read_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic         sel,
  input  logic         xlate,
  input  logic [W-1:0] mask_val,
  input  logic [W-1:0] run_val,
  output logic [W-1:0] rdata
);
  import pmr_pkg::*;

  logic [W-1:0] raw_src  [NUM_SRC];
  logic [W-1:0] view_src [NUM_SRC];

  always_comb begin
    raw_src[SEL_MASK] = mask_val;
    raw_src[SEL_RUN]  = run_val;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_view
    pmr_view_xlate #(.W(W)) u_xlate (
      .en   (xlate),
      .raw  (raw_src[g]),
      .view (view_src[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= view_src[sel];
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R2
endmodule

// File: rtl/prio_mask_unit.sv
module prio_mask_unit #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_ext_en,
  input  logic              grp0_route,
  input  logic              acc_ns,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PRIO_W-1:0] wdata,
  output logic [PRIO_W-1:0] rdata,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              mask_pass,
  output logic              reeval
);
  import pmr_pkg::*;

  logic              xlate;
  logic              mask_wr;
  logic [PRIO_W-1:0] mask_q;

  always_comb begin
    xlate   = sec_ext_en && grp0_route && acc_ns;
    mask_wr = wr_en && (pmr_sel_e'(reg_sel) == SEL_MASK);
  end

  pmr_mask_reg #(.W(PRIO_W)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (mask_wr),
    .xlate  (xlate),
    .wdata  (wdata),
    .mask_q (mask_q),
    .upd_q  (reeval)
  );

  pmr_read_port #(.W(PRIO_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .sel      (reg_sel),
    .xlate    (xlate),
    .mask_val (mask_q),
    .run_val  (run_prio),
    .rdata    (rdata)
  );

  always_comb mask_pass = (cand_prio < mask_q);

  AST_ZERO_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !mask_pass); // R9
  AST_HIDE_RUN: assert property (@(posedge clk) disable iff (rst)
    (rd_en && xlate && reg_sel && !run_prio[PRIO_W-1]) |=> (rdata == '0)); // R4
  AST_RAW_RUN: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !xlate && reg_sel) |=> (rdata == $past(run_prio))); // R3
endmodule

// File: tb/prio_mask_unit_bench.sv
module prio_mask_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_ext_en = 1'b0, grp0_route = 1'b0, acc_ns = 1'b0, reg_sel = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, run_prio = 8'hFF, cand_prio = '0;
  logic [7:0] rdata;
  logic       mask_pass, reeval;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_mask = '0;
  logic [7:0] m_rd = '0;

  always #5 clk = ~clk;

  prio_mask_unit u_prio_mask_unit (
    .clk(clk), .rst(rst), .sec_ext_en(sec_ext_en), .grp0_route(grp0_route),
    .acc_ns(acc_ns), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .run_prio(run_prio), .cand_prio(cand_prio),
    .mask_pass(mask_pass), .reeval(reeval)
  );

  function automatic logic [7:0] ns_view(logic [7:0] v);
    if (!v[7]) return 8'h00;
    if (v == 8'hFF) return 8'hFF;
    return {v[6:0], 1'b0};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic op(string tag, bit w, bit r, bit sel, logic [7:0] wd,
                    bit ns, bit se, bit gr, logic [7:0] rp, logic [7:0] cp);
    bit xl, acc;
    logic [7:0] src;
    string t;
    @(negedge clk);
    wr_en = w; rd_en = r; reg_sel = sel; wdata = wd; acc_ns = ns;
    sec_ext_en = se; grp0_route = gr; run_prio = rp; cand_prio = cp;
    xl  = se && gr && ns;
    src = sel ? rp : m_mask;
    t = tag;
    if (t == "") begin
      if (sel) t = "R8";
      else if (!xl) t = "R2";
      else if (m_mask[7]) t = "R5";
      else t = "R4";
    end
    if (r) m_rd = xl ? ns_view(src) : src;
    acc = w && !sel && !(xl && !m_mask[7]);
    @(posedge clk);
    #1;
    if (acc) m_mask = xl ? {1'b1, wd[7:1]} : wd;
    chk(t, rdata, m_rd);
    chk("R10", {7'd0, reeval}, {7'd0, acc});
    chk("R9", {7'd0, mask_pass}, {7'd0, cp < m_mask});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1", rdata, 8'h00);
    chk("R1", {7'd0, reeval}, 8'h00);
    chk("R1", {7'd0, mask_pass}, 8'h00);
    @(negedge clk); rst = 1'b0;
    op("R1", 0, 1, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h00);

    // R2 raw secure write and read
    op("R2", 1, 0, 0, 8'hA5, 0, 1, 1, 8'hFF, 8'h00);
    op("R2", 0, 1, 0, 8'h00, 0, 1, 1, 8'hFF, 8'hA4);
    op("R5", 0, 1, 0, 8'h00, 1, 1, 1, 8'hFF, 8'hA5);
    // R3 any condition off gives raw
    op("R3", 0, 1, 0, 8'h00, 1, 0, 1, 8'hFF, 8'h00);
    op("R3", 0, 1, 0, 8'h00, 1, 1, 0, 8'hFF, 8'h00);
    op("R3", 1, 0, 0, 8'h30, 1, 0, 1, 8'hFF, 8'h00);
    op("R3", 0, 1, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h00);
    // R4 hidden, R6 blocked write
    op("R4", 0, 1, 0, 8'h00, 1, 1, 1, 8'hFF, 8'h00);
    op("R6", 1, 0, 0, 8'h55, 1, 1, 1, 8'hFF, 8'h00);
    op("R6", 0, 1, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h2F);
    // R7 translated writes
    op("R7", 1, 0, 0, 8'h80, 0, 1, 1, 8'hFF, 8'h00);
    op("R7", 1, 0, 0, 8'hFE, 1, 1, 1, 8'hFF, 8'h00);
    op("R7", 0, 1, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h00);
    op("R5", 0, 1, 0, 8'h00, 1, 1, 1, 8'hFF, 8'h00);
    op("R7", 1, 0, 0, 8'hFF, 1, 1, 1, 8'hFF, 8'h00);
    op("R7", 0, 1, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h00);
    op("R7", 1, 0, 0, 8'h00, 1, 1, 1, 8'hFF, 8'h00);
    op("R7", 0, 1, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h00);
    // R8 running priority view, write ignored
    op("R8", 0, 1, 1, 8'h00, 1, 1, 1, 8'h40, 8'h00);
    op("R8", 0, 1, 1, 8'h00, 1, 1, 1, 8'hC0, 8'h00);
    op("R8", 0, 1, 1, 8'h00, 1, 1, 1, 8'hFF, 8'h00);
    op("R8", 0, 1, 1, 8'h00, 0, 1, 1, 8'h40, 8'h00);
    op("R8", 1, 0, 1, 8'h12, 0, 1, 1, 8'hFF, 8'h00);
    op("R8", 0, 1, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h00);
    // R11 read and write together
    op("R11", 1, 1, 0, 8'h10, 0, 1, 1, 8'hFF, 8'h00);
    op("R11", 0, 1, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h00);
    // R9 boundary of the compare
    op("R9", 0, 0, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h0F);
    op("R9", 0, 0, 0, 8'h00, 0, 1, 1, 8'hFF, 8'h10);

    for (int i = 0; i < 600; i++) begin
      logic [7:0] wd, rp, cp;
      bit w, r, sel, ns, se, gr;
      wd = 8'($urandom); rp = 8'($urandom); cp = 8'($urandom);
      w = ($urandom % 2) == 0; r = ($urandom % 3) != 0;
      sel = ($urandom % 4) == 0; ns = ($urandom % 2) == 0;
      se = ($urandom % 4) != 0; gr = ($urandom % 4) != 0;
      if (i % 50 == 0) wd = 8'hFE;
      if (i % 37 == 0) rp = 8'hFF;
      op("", w, r, sel, wd, ns, se, gr, rp, cp);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule